// File: doc/BRIEF.md
# Binary Early/Late Phase Detector

This block is the decision stage of a clock-recovery loop. On every recovered-clock cycle it receives three samples of the serial stream: one at the centre of the previous bit, one near the bit boundary, and one at the centre of the current bit. When the two centre samples differ, a data transition has occurred. The boundary sample then shows on which side of that transition the clock edge fell. The block turns this into a three-valued pump command: raise frequency, lower frequency, or hold.

The command is delivered on two registered strobes, `pumpUp` and `pumpDown`. Either may be high, but never both. When both are low, the charge pump leaves its output floating, so the loop is steered only at transitions and drifts undisturbed through runs of identical bits. The block also delivers the retimed data, which is the registered current-centre sample. An active-high enable travels down the pipeline with the samples and forces hold for any cycle in which it was low. A synchronous reset clears every register.

Top module: `bbPhaseDetect`

## Requirements
- R1: In the cycle after a rising clock edge at which `rst` is high, `pumpUp`, `pumpDown` and `retimedData` are all 0.
- R2: If the samples captured at edge k have `sampPrev` != `sampCur` and `sampEdge` == `sampCur`, with `enable` high, then `pumpUp`=1 and `pumpDown`=0 after edge k+1. This is the late-clock case.
- R3: If the samples captured at edge k have `sampPrev` != `sampCur` and `sampEdge` == `sampPrev`, with `enable` high, then `pumpDown`=1 and `pumpUp`=0 after edge k+1. This is the early-clock case.
- R4: If the samples captured at edge k have `sampPrev` == `sampCur`, then both strobes are 0 after edge k+1, whatever the value of `sampEdge`.
- R5: `pumpUp` and `pumpDown` are never both 1.
- R6: If `enable` is 0 at edge k, both strobes are 0 after edge k+1, whatever the samples captured at edge k.
- R7: After every edge k at which `rst` is low, `retimedData` equals the `sampCur` value captured at edge k.
- R8: A new decision is produced on every cycle with no bubbles, so a stream of sample sets presented on consecutive edges yields the matching commands on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Detector enable, active high; low forces hold |
| sampPrev | input | 1 | Sample at the previous bit centre |
| sampEdge | input | 1 | Sample near the expected bit boundary |
| sampCur | input | 1 | Sample at the current bit centre |
| pumpUp | output | 1 | Raise-frequency strobe (charge pump sources) |
| pumpDown | output | 1 | Lower-frequency strobe (charge pump sinks) |
| retimedData | output | 1 | Registered current-centre sample |

## Verification
Some properties are checked by the assertions on every cycle. These are the exclusivity of the two strobes, the clearing effect of reset, the one-cycle path from the centre sample to `retimedData`, and the mapping from each captured sample set, together with its enable, to up, down or hold two edges later. The bench's scenarios cover the rest. They show that both polarities of each transition type give the same command. They show that a reset in mid-run cancels a pending command. They also show that a stream of mixed decisions comes out back to back in the order it went in.

// File: rtl/bbpdPkg.sv
package bbpdPkg;

  // Classification of one captured sample set, passed from datapath to control.
  typedef struct packed {
    logic enabled;        // enable was high when the samples were taken
    logic transition;     // the two centre samples differ
    logic boundaryAfter;  // boundary sample matches the current-centre sample
  } edgeInfo_t;

  // Pump command held in the control register.
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_UP   = 2'b01,
    CMD_DOWN = 2'b10
  } pumpCmd_e;

endpackage

// File: rtl/bbpdDatapath.sv
module bbpdDatapath
  import bbpdPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      sampPrev,
  input  logic      sampEdge,
  input  logic      sampCur,
  output edgeInfo_t info,
  output logic      retimedData
);

  logic prevQ;
  logic edgeQ;
  logic curQ;
  logic enQ;

  // Capture stage: all three samples and the enable are taken on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ <= 1'b0;
      edgeQ <= 1'b0;
      curQ  <= 1'b0;
      enQ   <= 1'b0;
    end else begin
      prevQ <= sampPrev;
      edgeQ <= sampEdge;
      curQ  <= sampCur;
      enQ   <= enable;
    end
  end

  // Classify the captured set for the control stage.
  always_comb begin
    info.enabled       = enQ;
    info.transition    = prevQ ^ curQ;
    info.boundaryAfter = ~(edgeQ ^ curQ);
  end

  assign retimedData = curQ;

endmodule

// File: rtl/bbpdControl.sv
module bbpdControl
  import bbpdPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  edgeInfo_t info,
  output logic      pumpUp,
  output logic      pumpDown
);

  pumpCmd_e cmdNext;
  pumpCmd_e cmdQ;

  // Decision: with no transition or when disabled, leave the pump floating.
  // A boundary sample that already shows the new bit means the clock is late.
  always_comb begin
    cmdNext = CMD_HOLD;
    if (info.enabled && info.transition) begin
      cmdNext = info.boundaryAfter ? CMD_UP : CMD_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ <= CMD_HOLD;
    end else begin
      cmdQ <= cmdNext;
    end
  end

  assign pumpUp   = (cmdQ == CMD_UP);
  assign pumpDown = (cmdQ == CMD_DOWN);

endmodule

// File: rtl/bbPhaseDetect.sv
module bbPhaseDetect
  import bbpdPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sampPrev,
  input  logic sampEdge,
  input  logic sampCur,
  output logic pumpUp,
  output logic pumpDown,
  output logic retimedData
);

  edgeInfo_t edgeInfo;

  bbpdDatapath u_datapath (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .sampPrev    (sampPrev),
    .sampEdge    (sampEdge),
    .sampCur     (sampCur),
    .info        (edgeInfo),
    .retimedData (retimedData)
  );

  bbpdControl u_control (
    .clk      (clk),
    .rst      (rst),
    .info     (edgeInfo),
    .pumpUp   (pumpUp),
    .pumpDown (pumpDown)
  );

endmodule

// File: rtl/bbpdChecker.sv
module bbpdChecker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic sampPrev,
  input logic sampEdge,
  input logic sampCur,
  input logic pumpUp,
  input logic pumpDown,
  input logic retimedData
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pumpUp && !pumpDown && !retimedData));

  assert_late_gives_up_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(enable, 2) &&
     ($past(sampPrev, 2) != $past(sampCur, 2)) &&
     ($past(sampEdge, 2) == $past(sampCur, 2)))
    |-> (pumpUp && !pumpDown));

  assert_early_gives_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(enable, 2) &&
     ($past(sampPrev, 2) != $past(sampCur, 2)) &&
     ($past(sampEdge, 2) == $past(sampPrev, 2)))
    |-> (pumpDown && !pumpUp));

  assert_no_edge_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(sampPrev, 2) == $past(sampCur, 2)))
    |-> (!pumpUp && !pumpDown));

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pumpUp, pumpDown}));

  assert_disable_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(enable, 2)) |-> (!pumpUp && !pumpDown));

  assert_retime_path_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (retimedData == $past(sampCur)));

endmodule

bind bbPhaseDetect bbpdChecker u_bbpdChecker (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .sampPrev    (sampPrev),
  .sampEdge    (sampEdge),
  .sampCur     (sampCur),
  .pumpUp      (pumpUp),
  .pumpDown    (pumpDown),
  .retimedData (retimedData)
);

// File: tb/tb_bbPhaseDetect.sv
`timescale 1ns/1ps
module tb_bbPhaseDetect;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic sampPrev = 1'b0;
  logic sampEdge = 1'b0;
  logic sampCur = 1'b0;
  logic pumpUp;
  logic pumpDown;
  logic retimedData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bbPhaseDetect dut (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .sampPrev    (sampPrev),
    .sampEdge    (sampEdge),
    .sampCur     (sampCur),
    .pumpUp      (pumpUp),
    .pumpDown    (pumpDown),
    .retimedData (retimedData)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {up,down,data} actual %b expected %b", req, act, exp);
    end
  endtask

  // Present one sample set; check retimed data after the capture edge and
  // the command after the following edge.
  task automatic oneSet(input string req, input logic p, input logic b, input logic c,
                        input logic en, input logic expUp, input logic expDn);
    @(negedge clk);
    sampPrev = p; sampEdge = b; sampCur = c; enable = en;
    @(negedge clk);
    checks++;
    if (retimedData !== c) begin
      errors++;
      $display("FAIL R7 (%s): retimedData actual %b expected %b", req, retimedData, c);
    end
    @(negedge clk);
    check(req, {pumpUp, pumpDown, retimedData}, {expUp, expDn, c});
    checks++;
    if (pumpUp && pumpDown) begin
      errors++;
      $display("FAIL R5: strobes actual 11 expected at most one high");
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    sampPrev = 1'b1; sampEdge = 1'b1; sampCur = 1'b1; enable = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state", {pumpUp, pumpDown, retimedData}, 3'b000);
    rst = 1'b0;
  endtask

  task automatic testLate();
    oneSet("R2 rising late", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    oneSet("R2 falling late", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic testEarly();
    oneSet("R3 rising early", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    oneSet("R3 falling early", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    oneSet("R4 zeros boundary high", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    oneSet("R4 ones boundary low", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    oneSet("R4 zeros quiet", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testDisable();
    oneSet("R6 late disabled", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    oneSet("R6 early disabled", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Consecutive sets, one per edge: up, down, hold, up, disabled, down.
  task automatic testStream();
    logic [3:0] setv [6];   // {en, p, b, c}
    logic [1:0] expv [6];   // {up, down}
    setv[0] = 4'b1011; expv[0] = 2'b10;
    setv[1] = 4'b1110; expv[1] = 2'b01;
    setv[2] = 4'b1101; expv[2] = 2'b00;
    setv[3] = 4'b1100; expv[3] = 2'b10;
    setv[4] = 4'b0011; expv[4] = 2'b00;
    setv[5] = 4'b1001; expv[5] = 2'b01;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check($sformatf("R8 stream step %0d", i - 2),
              {pumpUp, pumpDown, 1'b0}, {expv[i-2], 1'b0});
      end
      if (i < 6) begin
        {enable, sampPrev, sampEdge, sampCur} = setv[i];
      end else begin
        {enable, sampPrev, sampEdge, sampCur} = 4'b1000;
      end
    end
  endtask

  // A reset asserted with an up command pending must cancel it.
  task automatic testMidReset();
    @(negedge clk);
    sampPrev = 1'b0; sampEdge = 1'b1; sampCur = 1'b1; enable = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {pumpUp, pumpDown, retimedData}, 3'b000);
    rst = 1'b0;
    sampPrev = 1'b0; sampEdge = 1'b0; sampCur = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    testReset();
    testLate();
    testEarly();
    testHold();
    testDisable();
    testStream();
    testMidReset();
    oneSet("R2 after reset", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule